// File: doc/BRIEF.md
# Fixed-Point Requantization Multiplier

This unit works on signed 32-bit fixed-point words. It performs the scaling step that brings an accumulator back into range after an integer convolution or matrix product. An operation code picks one of three functions. The first multiplies two Q0.31 operands, doubles the product and keeps the rounded high half. The second divides one operand by a power of two, rounding to nearest. The third multiplies by a quantized multiplier and then divides the product by a power of two.

Every operation is issued with a single strobe. The inputs are two operands, a 5-bit shift amount and the operation code. The result is registered and appears one clock later, qualified by an output strobe. The result register keeps its value until the next issue. A new operation can start on every cycle.

Top module: `fxq_requant_unit`

## Requirements
- R1: In multiply mode the result is bits [62:31] of the 64-bit signed product opA*opB plus 2^30; the 2^30 rounding term is added whatever the sign of the product.
- R2: When opA and opB both equal -2^31, multiply mode returns 2^31-1 (0x7FFFFFFF). No other operand pair saturates; for example -2^31 * (2^31-1) returns -(2^31-1).
- R3: In shift mode the result is opA divided by 2^shAmt and rounded to nearest. A positive value exactly halfway rounds up (5 shifted by 1 gives 3).
- R4: In shift mode a negative value exactly halfway rounds away from zero (-5 shifted by 1 gives -3; -6 shifted by 2 gives -2).
- R5: A shift amount of 0 returns opA unchanged. A shift amount of 31 gives correctly rounded results: -2^31 gives -1, 2^30 gives 1, -2^30 gives -1.
- R6: Requantize mode returns the R3/R4 rounding shift, by shAmt, of the R1/R2 multiply result of opA and opB.
- R7: Operation codes on opSel: 0 is multiply, 1 is shift (opB is ignored), 2 and 3 are both requantize. Multiply mode ignores shAmt.
- R8: outValid is high in exactly the cycle after each cycle in which inValid is sampled high. The result of that issue is on `result` in the same cycle.
- R9: While inValid is low, `result` holds its last value whatever the other inputs do.
- R10: Reset is synchronous and active low. While it is applied, outValid and result are cleared to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Issue strobe for the operation on the other inputs |
| opSel | input | 2 | Operation code (see R7) |
| opA | input | 32 | First signed operand, or the value to shift |
| opB | input | 32 | Second signed operand (the quantized multiplier) |
| shAmt | input | 5 | Right-shift amount, 0 to 31 |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| result | output | 32 | Registered signed result |

## Verification
The hardest situations to reach are the rounding ties. They occur only when the bits shifted out equal exactly one half, and in requantize mode that pattern must come out of the multiplier rather than being applied directly. The bench drives the tie patterns directly in shift mode, for positive and negative values and at shift amounts 1, 2 and 31. It reaches the requantize corners by choosing opB = 2^31-1, so that the product passes the operand through nearly unchanged, and by issuing the lone saturating pair (-2^31, -2^31) followed by a shift. A deterministic pseudo-random sweep over all operation codes is compared against a 64-bit integer model.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

  typedef enum logic [1:0] {
    OP_MUL         = 2'd0,
    OP_SHIFT       = 2'd1,
    OP_REQUANT     = 2'd2,
    OP_REQUANT_ALT = 2'd3
  } fxq_op_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;      // capture a new result this cycle
    logic useMul;    // shifter input comes from the multiplier
    logic useShift;  // apply the rounding right shift
  } fxq_strobe_t;

endpackage

// File: rtl/fxq_ctrl.sv
module fxq_ctrl
  import fxq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opSel,
  output fxq_strobe_t strobes,
  output logic        outValid
);

  fxq_op_e opCode;
  assign opCode = fxq_op_e'(opSel);

  always_comb begin
    strobes.load     = inValid;
    strobes.useMul   = 1'b1;
    strobes.useShift = 1'b1;
    unique case (opCode)
      OP_MUL:   strobes.useShift = 1'b0;
      OP_SHIFT: strobes.useMul   = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

// File: rtl/fxq_datapath.sv
module fxq_datapath
  import fxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fxq_strobe_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shAmt,
  output logic [DATA_W-1:0] result
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_VAL = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] ONE_VAL = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [PROD_W-1:0] ROUND_C = {{(PROD_W-1){1'b0}}, 1'b1} << (DATA_W - 2);

  // Doubling high-half multiply
  logic [PROD_W-1:0] prodFull;
  logic [PROD_W-1:0] prodRounded;
  logic [DATA_W-1:0] mulHi;
  logic              mulSat;
  logic [DATA_W-1:0] mulRes;
  logic              unusedRoundBits;

  assign prodFull    = {{DATA_W{opA[DATA_W-1]}}, opA} * {{DATA_W{opB[DATA_W-1]}}, opB};
  assign prodRounded = prodFull + ROUND_C;
  assign mulHi       = prodRounded[PROD_W-2:DATA_W-1];
  assign unusedRoundBits = ^{prodRounded[PROD_W-1], prodRounded[DATA_W-2:0]};
  assign mulSat      = (opA == MIN_VAL) && (opB == MIN_VAL);
  assign mulRes      = mulSat ? MAX_VAL : mulHi;

  // Rounding arithmetic right shift
  logic [DATA_W-1:0] shIn;
  logic [DATA_W-1:0] shMask;
  logic [DATA_W-1:0] shThresh;
  logic [DATA_W-1:0] shFloor;
  logic              shBump;
  logic [DATA_W-1:0] shRes;

  assign shIn     = strobes.useMul ? mulRes : opA;
  assign shMask   = (ONE_VAL << shAmt) - ONE_VAL;
  assign shThresh = (shMask >> 1) + {{(DATA_W-1){1'b0}}, shIn[DATA_W-1]};
  assign shFloor  = $unsigned($signed(shIn) >>> shAmt);
  assign shBump   = (shIn & shMask) > shThresh;
  assign shRes    = shFloor + {{(DATA_W-1){1'b0}}, shBump};

  always_ff @(posedge clk) begin
    if (!rstN)
      result <= '0;
    else if (strobes.load)
      result <= strobes.useShift ? shRes : shIn;
  end

  // R2
  min_square_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.useMul && !strobes.useShift &&
     opA == MIN_VAL && opB == MIN_VAL) |=> (result == MAX_VAL));
  // R5
  zero_shift_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.useMul && strobes.useShift && shAmt == '0)
      |=> (result == $past(opA)));
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(result));
  // R10
  reset_result_chk: assert property (@(posedge clk)
    !rstN |=> (result == '0));

endmodule

// File: rtl/fxq_requant_unit.sv
module fxq_requant_unit
  import fxq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opSel,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [4:0]  shAmt,
  output logic        outValid,
  output logic [31:0] result
);

  fxq_strobe_t strobes;

  fxq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fxq_datapath #(.DATA_W(32), .SH_W(5)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .shAmt   (shAmt),
    .result  (result)
  );

endmodule

// File: tb/fxq_requant_unit_bench.sv
`timescale 1ns/1ps
module fxq_requant_unit_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  opSel;
  logic [31:0] opA, opB;
  logic [4:0]  shAmt;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] MINV = 32'h8000_0000;
  localparam logic [31:0] MAXV = 32'h7FFF_FFFF;

  always #10 clk = ~clk;

  fxq_requant_unit u_fxq_requant_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .shAmt(shAmt), .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] refMul(logic [31:0] a, logic [31:0] b);
    longint sa, sb, p;
    if (a == MINV && b == MINV) return MAXV;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    p = (sa * sb + 64'sd1073741824) >>> 31;
    return p[31:0];
  endfunction

  function automatic logic [31:0] refShift(logic [31:0] x, logic [4:0] e);
    longint sx, half, q;
    if (e == 0) return x;
    sx = longint'($signed(x));
    half = 64'sd1 <<< (e - 1);
    if (sx >= 0) q = (sx + half) >>> e;
    else         q = -((-sx + half) >>> e);
    return q[31:0];
  endfunction

  function automatic logic [31:0] refOp(logic [1:0] op, logic [31:0] a,
                                         logic [31:0] b, logic [4:0] e);
    case (op)
      2'd0:    return refMul(a, b);
      2'd1:    return refShift(a, e);
      default: return refShift(refMul(a, b), e);
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation, then sample at the following falling edge
  task automatic issue(logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] e);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; shAmt = e;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runOp(string req, logic [1:0] op, logic [31:0] a,
                       logic [31:0] b, logic [4:0] e);
    issue(op, a, b, e);
    chk({req, " valid"}, {31'd0, outValid}, 32'd1);
    chk(req, result, refOp(op, a, b, e));
  endtask

  task automatic t_reset;
    rstN = 1'b0; inValid = 1'b1; opSel = 2'd0; opA = MAXV; opB = MAXV; shAmt = '0;
    repeat (3) @(negedge clk);
    chk("R10 outValid", {31'd0, outValid}, 32'd0);
    chk("R10 result", result, 32'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_mult;
    runOp("R1 mul pos", 2'd0, 32'h4000_0000, 32'h4000_0000, 5'd0);
    chk("R1 literal", result, 32'h2000_0000);
    runOp("R1 mul neg round", 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    runOp("R1 mul mixed", 2'd0, 32'h1234_5678, 32'h8765_4321, 5'd0);
    runOp("R1 mul tie", 2'd0, 32'h0000_0001, 32'h4000_0000, 5'd0);
    runOp("R2 min*min", 2'd0, MINV, MINV, 5'd0);
    chk("R2 literal", result, MAXV);
    runOp("R2 min*max", 2'd0, MINV, MAXV, 5'd0);
    chk("R2 no sat", result, 32'h8000_0001);
  endtask

  task automatic t_shift;
    runOp("R3 5>>1", 2'd1, 32'd5, 32'hDEAD_BEEF, 5'd1);
    chk("R3 literal", result, 32'd3);
    runOp("R3 6>>2", 2'd1, 32'd6, 32'd0, 5'd2);
    runOp("R3 7>>2", 2'd1, 32'd7, 32'd0, 5'd2);
    runOp("R4 -5>>1", 2'd1, -32'sd5, 32'd0, 5'd1);
    chk("R4 literal", result, -32'sd3);
    runOp("R4 -6>>2", 2'd1, -32'sd6, 32'd0, 5'd2);
    chk("R4 literal2", result, -32'sd2);
    runOp("R4 -7>>2", 2'd1, -32'sd7, 32'd0, 5'd2);
    runOp("R5 sh0", 2'd1, 32'hCAFE_F00D, 32'd0, 5'd0);
    chk("R5 passthrough", result, 32'hCAFE_F00D);
    runOp("R5 min>>31", 2'd1, MINV, 32'd0, 5'd31);
    chk("R5 min literal", result, 32'hFFFF_FFFF);
    runOp("R5 half>>31", 2'd1, 32'h4000_0000, 32'd0, 5'd31);
    chk("R5 half literal", result, 32'd1);
    runOp("R5 -half>>31", 2'd1, 32'hC000_0000, 32'd0, 5'd31);
    chk("R5 -half literal", result, 32'hFFFF_FFFF);
    runOp("R5 max>>31", 2'd1, MAXV, 32'd0, 5'd31);
  endtask

  task automatic t_requant;
    runOp("R6 rq", 2'd2, 32'd1000, MAXV, 5'd3);
    runOp("R6 rq neg tie", 2'd2, -32'sd12, MAXV, 5'd3);
    runOp("R6 rq sat", 2'd2, MINV, MINV, 5'd4);
    runOp("R6 rq big", 2'd2, 32'h7654_3210, 32'h5A5A_5A5A, 5'd9);
    runOp("R7 op3 rq", 2'd3, 32'h0123_4567, 32'h6000_0000, 5'd5);
    runOp("R6 rq sh31", 2'd2, MAXV, MAXV, 5'd31);
  endtask

  task automatic t_ignored;
    logic [31:0] expV;
    expV = refMul(32'h3333_3333, 32'hC000_0001);
    runOp("R7 mul ignores shAmt", 2'd0, 32'h3333_3333, 32'hC000_0001, 5'd17);
    chk("R7 mul ignores shAmt lit", result, expV);
    runOp("R7 shift ignores opB", 2'd1, 32'h0000_0100, 32'h1234_5678, 5'd4);
    chk("R7 shift ignores opB lit", result, 32'h0000_0010);
  endtask

  task automatic t_hold;
    logic [31:0] kept;
    runOp("R8 pre-hold", 2'd1, 32'd77, 32'd0, 5'd0);
    kept = result;
    @(negedge clk);
    opSel = 2'd0; opA = MAXV; opB = MAXV; shAmt = 5'd3;
    @(negedge clk);
    chk("R8 valid low", {31'd0, outValid}, 32'd0);
    chk("R9 hold", result, kept);
    @(negedge clk);
    opA = 32'h1111_1111;
    @(negedge clk);
    chk("R9 hold2", result, kept);
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr = 32'hACE1_2468;
    logic [31:0] a, b;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      runOp("R6 sweep", lfsr[5:4], a, b, lfsr[12:8]);
    end
  endtask

  task automatic t_backToBack;
    @(negedge clk);
    inValid = 1'b1; opSel = 2'd1; opA = 32'd9; opB = 32'd0; shAmt = 5'd1;
    @(negedge clk);
    chk("R8 b2b first", result, 32'd5);
    opA = -32'sd9;
    @(negedge clk);
    chk("R8 b2b valid", {31'd0, outValid}, 32'd1);
    chk("R4 b2b second", result, -32'sd5);
    inValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_mult();
    t_shift();
    t_requant();
    t_ignored();
    t_hold();
    t_backToBack();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule